// File: doc/BRIEF.md
# Windowed Software Watchdog Supervisor

This block watches a running program through a windowed watchdog and watches the supply through an external under-voltage flag. It drives two outputs. The first is an active-low system reset. The second is a system-enable line that downstream logic uses to gate hazardous actions, such as energising actuators, until the software has shown that it runs correctly.

Once the supply is good, the block holds reset for a power-on delay of one watchdog period. It then repeats a fixed cycle. Each cycle begins with a closed interval, where a kick from software is treated as an error. An open interval follows, where a kick is accepted. A kick in the open interval starts a fresh cycle. A kick in the closed interval, or no kick before the open interval ends, produces a short reset pulse, after which a new cycle begins.

Both inputs pass through two-flop synchronisers and pulse-width qualifiers. A short glitch on either input therefore has no effect. All durations are counted in clock ticks and derived from a single period parameter `TICKS_WD`. The closed interval is 0.8 of the period, the open interval 0.4, the watchdog reset pulse 1/40, and the power-on delay one full period.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rstN` is low, `sysResetN` and `sysEnable` are both 0.
- R2: After `uvFlag` returns to 0, `sysResetN` stays 0 for `TICKS_WD` ticks plus at most 10 ticks of synchroniser and qualifier latency, then goes to 1.
- R3: `uvFlag` held at 1 for at least `UV_QUAL_TICKS` ticks drives `sysResetN` and `sysEnable` to 0. A pulse shorter than `UV_QUAL_TICKS` ticks leaves both outputs unchanged.
- R4: A kick is recognised within the first `TICKS_WD*4/5` ticks after `sysResetN` rises (the closed interval). Such a kick is a fault, and `sysResetN` falls within a few ticks of it.
- R5: A kick recognised during the following `TICKS_WD*2/5` ticks (the open interval) keeps `sysResetN` at 1 and starts a new closed interval.
- R6: If no kick arrives, `sysResetN` falls exactly `TICKS_WD*6/5` ticks after it rose.
- R7: A watchdog reset pulse keeps `sysResetN` at 0 for exactly `TICKS_WD/40` ticks. After the pulse a new cycle begins.
- R8: `sysEnable` rises only on the third consecutive valid kick (`ENABLE_CLEARS`). It is never 1 while `sysResetN` is 0.
- R9: Any reset (watchdog fault, timeout or under-voltage) drives `sysEnable` to 0 and restarts the count of valid kicks from zero.
- R10: A kick is a low pulse on `clrStrobeN`, which idles at 1. A pulse that is low for fewer than `CLR_MIN_TICKS` ticks is not recognised.
- R11: Kicks that arrive during the power-on delay or during a watchdog reset pulse are ignored. The first closed interval starts on the tick that `sysResetN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations count its ticks |
| rstN | input | 1 | Asynchronous active-low register reset |
| clrStrobeN | input | 1 | Raw software kick, active-low pulse |
| uvFlag | input | 1 | Raw under-voltage flag from an external comparator, 1 = supply low |
| sysResetN | output | 1 | Registered active-low system reset |
| sysEnable | output | 1 | Registered system-enable output |

## Verification
The hardest case to reach is the restart of the kick count after a fault. The enable output only shows a difference if the design has already seen some valid kicks, then faults, and then sees fewer than three more. The stimulus therefore gives two valid kicks and then a deliberately early kick. After the watchdog pulse it checks that enable stays low on the next valid kick, and that enable rises only on the third kick after the fault. Interval boundaries are reached by timing each kick from the observed rising edge of reset. Each high and low run of reset is measured against an expected length queued in advance.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [2:0] {
    PH_UV     = 3'd0,
    PH_POR    = 3'd1,
    PH_CLOSED = 3'd2,
    PH_OPEN   = 3'd3,
    PH_PULSE  = 3'd4
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   restart;
    phase_e phase;
  } tmrCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic clrHit;
    logic uvActive;
    logic phaseDone;
  } dpStat_t;

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdsup_datapath.sv
module wdsup_datapath
  import wdsup_pkg::*;
#(
  parameter int TICKS_WD      = 4000,
  parameter int UV_QUAL_TICKS = 40,
  parameter int CLR_MIN_TICKS = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clrStrobeN,
  input  logic    uvFlag,
  input  tmrCmd_t cmd,
  output dpStat_t stat
);
  localparam int CNT_W     = $clog2(TICKS_WD + 1);
  localparam int CLOSED_LEN = TICKS_WD * 4 / 5;
  localparam int OPEN_LEN   = TICKS_WD * 2 / 5;
  localparam int PULSE_LEN  = (TICKS_WD / 40 < 1) ? 1 : TICKS_WD / 40;
  localparam int POR_LEN    = TICKS_WD;
  localparam int LOW_W      = $clog2(CLR_MIN_TICKS + 1);
  localparam int HI_W       = $clog2(UV_QUAL_TICKS + 1);
  localparam logic [LOW_W-1:0] LOW_HIT  = LOW_W'(CLR_MIN_TICKS - 1);
  localparam logic [HI_W-1:0]  HI_QUAL  = HI_W'(UV_QUAL_TICKS - 1);

  logic clrSync, uvSync;

  wdsup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clrSync (
    .clk(clk), .rstN(rstN), .din(clrStrobeN), .dout(clrSync));

  wdsup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_uvSync (
    .clk(clk), .rstN(rstN), .din(uvFlag), .dout(uvSync));

  // kick width qualifier: one hit per low pulse, once it is wide enough
  logic [LOW_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowRun <= '0;
    else if (clrSync)           lowRun <= '0;
    else if (lowRun != LOW_HIT + 1'b1) lowRun <= lowRun + 1'b1;
  end
  assign stat.clrHit = !clrSync && (lowRun == LOW_HIT);

  // under-voltage qualifier
  logic [HI_W-1:0] hiRun;
  logic            uvActive;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= '0;
      uvActive <= 1'b1;
    end else if (!uvSync) begin
      hiRun    <= '0;
      uvActive <= 1'b0;
    end else if (hiRun == HI_QUAL) begin
      uvActive <= 1'b1;
    end else begin
      hiRun <= hiRun + 1'b1;
    end
  end
  assign stat.uvActive = uvActive;

  // phase timer
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] lastTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tick <= '0;
    else if (cmd.restart) tick <= '0;
    else if (tick != lastTick) tick <= tick + 1'b1;
  end

  always_comb begin
    unique case (cmd.phase)
      PH_POR:    lastTick = CNT_W'(POR_LEN - 1);
      PH_CLOSED: lastTick = CNT_W'(CLOSED_LEN - 1);
      PH_OPEN:   lastTick = CNT_W'(OPEN_LEN - 1);
      PH_PULSE:  lastTick = CNT_W'(PULSE_LEN - 1);
      default:   lastTick = '0;
    endcase
  end
  assign stat.phaseDone = (tick == lastTick);

endmodule

// File: rtl/wdsup_control.sv
module wdsup_control
  import wdsup_pkg::*;
#(
  parameter int ENABLE_CLEARS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output tmrCmd_t cmd,
  output phase_e  phase,
  output logic    sysResetN,
  output logic    sysEnable
);
  localparam int GOOD_W = $clog2(ENABLE_CLEARS + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(ENABLE_CLEARS);

  phase_e           nextPh;
  logic [GOOD_W-1:0] goodCnt, nextGood;
  logic             nextRun;

  always_comb begin
    nextPh   = phase;
    nextGood = goodCnt;
    if (stat.uvActive) begin
      nextPh = PH_UV;
    end else begin
      unique case (phase)
        PH_UV:     nextPh = PH_POR;
        PH_POR:    if (stat.phaseDone) nextPh = PH_CLOSED;
        PH_CLOSED: begin
          if (stat.clrHit)         nextPh = PH_PULSE;
          else if (stat.phaseDone) nextPh = PH_OPEN;
        end
        PH_OPEN: begin
          if (stat.clrHit) begin
            nextPh = PH_CLOSED;
            if (goodCnt != GOOD_MAX) nextGood = goodCnt + 1'b1;
          end else if (stat.phaseDone) begin
            nextPh = PH_PULSE;
          end
        end
        PH_PULSE:  if (stat.phaseDone) nextPh = PH_CLOSED;
        default:   nextPh = PH_UV;
      endcase
    end
    nextRun = (nextPh == PH_CLOSED) || (nextPh == PH_OPEN);
    if (!nextRun) nextGood = '0;
  end

  // restart the timer on every phase change, and also when a kick
  // in the open interval opens a fresh closed interval
  assign cmd.restart = (nextPh != phase) || (phase == PH_UV);
  assign cmd.phase   = phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_UV;
      goodCnt   <= '0;
      sysResetN <= 1'b0;
      sysEnable <= 1'b0;
    end else begin
      phase     <= nextPh;
      goodCnt   <= nextGood;
      sysResetN <= nextRun;
      sysEnable <= nextRun && (nextGood == GOOD_MAX);
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdsup_pkg::*;
#(
  parameter int TICKS_WD      = 4000,
  parameter int UV_QUAL_TICKS = 40,
  parameter int CLR_MIN_TICKS = 2,
  parameter int ENABLE_CLEARS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic clrStrobeN,
  input  logic uvFlag,
  output logic sysResetN,
  output logic sysEnable
);
  tmrCmd_t tmrCmd;
  dpStat_t dpStat;
  phase_e  curPhase;

  wdsup_datapath #(
    .TICKS_WD(TICKS_WD), .UV_QUAL_TICKS(UV_QUAL_TICKS),
    .CLR_MIN_TICKS(CLR_MIN_TICKS), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .clrStrobeN(clrStrobeN), .uvFlag(uvFlag),
    .cmd(tmrCmd), .stat(dpStat));

  wdsup_control #(.ENABLE_CLEARS(ENABLE_CLEARS)) u_ctl (
    .clk(clk), .rstN(rstN), .stat(dpStat), .cmd(tmrCmd), .phase(curPhase),
    .sysResetN(sysResetN), .sysEnable(sysEnable));
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
  import wdsup_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    resetN,
  input logic    enable,
  input dpStat_t stat,
  input phase_e  phase
);
  // R3
  uv_forces_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.uvActive |=> (!resetN && !enable));

  // R8
  enable_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> resetN);

  // R8
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> $past(stat.clrHit));

  // R4
  closed_kick_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CLOSED && stat.clrHit && !stat.uvActive) |=> !resetN);

  // R5
  open_kick_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OPEN && stat.clrHit && !stat.uvActive) |=> (resetN && phase == PH_CLOSED));

  // R6
  open_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OPEN && stat.phaseDone && !stat.clrHit && !stat.uvActive) |=> !resetN);

  // R11
  por_ignores_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_POR && !stat.phaseDone && !stat.uvActive) |=> (phase == PH_POR && !resetN));

  // R9
  reset_drops_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetN) |-> !enable);
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk(clk), .rstN(rstN), .resetN(sysResetN), .enable(sysEnable),
  .stat(dpStat), .phase(curPhase));

// File: tb/wdog_supervisor_test.sv
`timescale 1ns/1ps
module wdog_supervisor_test;
  localparam int TWD = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrStrobeN = 1'b1;
  logic uvFlag = 1'b1;
  logic sysResetN, sysEnable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdog_supervisor #(.TICKS_WD(TWD), .UV_QUAL_TICKS(8), .CLR_MIN_TICKS(3),
                    .ENABLE_CLEARS(3)) uut (
    .clk(clk), .rstN(rstN), .clrStrobeN(clrStrobeN), .uvFlag(uvFlag),
    .sysResetN(sysResetN), .sysEnable(sysEnable));

  // expected reset runs: level of the run that ends, and its length range
  bit    expLvl[$];
  int    expLo[$];
  int    expHi[$];
  string expTag[$];

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic expectRun(bit lvl, int lo, int hi, string tag);
    expLvl.push_back(lvl); expLo.push_back(lo);
    expHi.push_back(hi);   expTag.push_back(tag);
  endtask

  // monitor: measure every run of sysResetN, compare with queued item
  bit lastLvl = 1'b0;
  int runLen  = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sysResetN == lastLvl) runLen++;
      else begin
        if (expLvl.size() > 0) begin
          automatic bit    l  = expLvl.pop_front();
          automatic int    lo = expLo.pop_front();
          automatic int    hi = expHi.pop_front();
          automatic string t  = expTag.pop_front();
          checkEq({t, " run level"}, int'(lastLvl), int'(l));
          checkRange({t, " run length"}, runLen, lo, hi);
        end
        lastLvl = sysResetN;
        runLen  = 1;
      end
    end
  end

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(int width);
    clrStrobeN = 1'b0;
    waitNeg(width);
    clrStrobeN = 1'b1;
  endtask

  // negedges until sysResetN is seen high
  task automatic waitRise(output int n);
    n = 0;
    while (sysResetN !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // kick at absolute offsets from a time origin t0 (negedges already passed = t)
  int t;
  task automatic kickAt(int at, int width);
    waitNeg(at - t);
    t = at;
    kick(width);
    t += width;
  endtask

  initial begin
    int n;
    waitNeg(3);
    // R1
    checkEq("R1 reset held", int'(sysResetN), 0);
    checkEq("R1 enable held", int'(sysEnable), 0);
    rstN = 1'b1;
    waitNeg(20);
    checkEq("R3 reset while supply low", int'(sysResetN), 0);

    // R2 power-on delay
    uvFlag = 1'b0;
    waitRise(n);
    checkRange("R2 power-on delay", n, TWD, TWD + 10);
    @(posedge clk);

    // sequence A: short kick ignored, three valid kicks, then timeout
    t = 0;
    expectRun(1'b1, 1495, 1515, "R5 R6 kicks then timeout");
    expectRun(1'b0, TWD/40, TWD/40, "R7 pulse after timeout");
    expectRun(1'b1, TWD*6/5, TWD*6/5, "R6 plain timeout");
    expectRun(1'b0, TWD/40, TWD/40, "R7 second pulse");
    kickAt(100, 2);
    waitNeg(20); t += 20;
    checkEq("R10 short kick ignored", int'(sysResetN), 1);
    kickAt(340, 4);
    waitNeg(10); t += 10;
    checkEq("R8 enable after one kick", int'(sysEnable), 0);
    kickAt(680, 4);
    waitNeg(10); t += 10;
    checkEq("R8 enable after two kicks", int'(sysEnable), 0);
    kickAt(1020, 4);
    waitNeg(10); t += 10;
    checkEq("R8 enable after three kicks", int'(sysEnable), 1);
    checkEq("R5 still running", int'(sysResetN), 1);
    // wait for timeout pulse, the free-running cycle and the second pulse
    while (expLvl.size() > 0) @(negedge clk);
    checkEq("R9 enable low after faults", int'(sysEnable), 0);

    // sequence B: two valid kicks then an early one
    @(posedge clk);
    t = 0;
    expectRun(1'b1, 775, 795, "R4 early kick");
    expectRun(1'b0, TWD/40, TWD/40, "R7 pulse after early kick");
    kickAt(340, 4);
    kickAt(680, 4);
    kickAt(780, 4);
    waitNeg(10);
    checkEq("R4 fault reset", int'(sysResetN), 0);
    checkEq("R9 enable cleared by fault", int'(sysEnable), 0);
    waitRise(n);
    @(posedge clk);

    // sequence C: kick count restarted, then under-voltage handling
    t = 0;
    kickAt(340, 4);
    waitNeg(10); t += 10;
    checkEq("R9 count restarted", int'(sysEnable), 0);
    kickAt(680, 4);
    kickAt(1020, 4);
    waitNeg(10); t += 10;
    checkEq("R8 enable after fresh three", int'(sysEnable), 1);
    waitNeg(1100 - t); t = 1100;
    uvFlag = 1'b1; waitNeg(3); uvFlag = 1'b0;
    waitNeg(17);
    checkEq("R3 glitch ignored reset", int'(sysResetN), 1);
    checkEq("R3 glitch ignored enable", int'(sysEnable), 1);
    uvFlag = 1'b1;
    waitNeg(20);
    checkEq("R3 under-voltage reset", int'(sysResetN), 0);
    checkEq("R3 under-voltage enable", int'(sysEnable), 0);
    waitNeg(10);
    uvFlag = 1'b0;
    waitNeg(200);
    kick(4);
    waitRise(n);
    checkRange("R2 R11 delay with kick inside", n + 204, TWD, TWD + 10);
    @(posedge clk);
    expectRun(1'b1, TWD*6/5, TWD*6/5, "R11 first window fresh");
    while (expLvl.size() > 0) @(negedge clk);
    waitNeg(20);
    checkEq("R7 new cycle after pulse", int'(sysResetN), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule